// File: doc/BRIEF.md
# Mains Phase Timing Unit

This block turns the pulse train from an external mains zero-crossing detector into a running estimate of mains phase. Each rising edge of the synchronised pulse is a phase-zero reference. The block measures the number of clock cycles between reference edges and accepts the result as the mains period only if it falls inside a window that covers both 50 Hz and 60 Hz supplies. Between edges, a phase counter advances in 256 equal steps per measured period. An accumulator carries the remainder, so the phase value is exact for any period.

The modem uses two services built on that phase. First, a transmit request is held until the mains phase equals a programmed 8-bit offset, and the block then emits a one-cycle start strobe. If the block is not synchronised to the mains, the request is released at once and the strobe is marked unsynchronised. Second, a receive-detect pulse captures the current phase and the lock state into a one-entry result slot with a valid/ready output. The zero-crossing input only takes effect while detection is enabled, because the pin may be serving as ordinary I/O.

Transmit requests use a valid/ready handshake. `tx_req_ready` is high whenever no request is pending, and a request is taken in a cycle with both signals high. The captured-phase output also uses valid/ready. Once `rx_ts_valid` is high, the phase and lock fields hold steady until a cycle with `rx_ts_ready` high. A receive-detect that arrives while the slot is full and not being drained is dropped.

Top module: `mains_phase_timer`

## Requirements
- R1: `zc_raw` passes through two synchronising flops. A low-to-high transition that is present at clock edge n is acted on by the period logic at clock edge n+2.
- R2: An accepted edge has a measured interval P, defined as cycles since the previous reference edge plus one, with MIN_PERIOD ≤ P ≤ MAX_PERIOD. Such an edge sets lock (`sync_lost` low), stores P as the period and restarts the phase at 0.
- R3: An edge whose interval is below MIN_PERIOD is a glitch. It does not change the period, the lock or the running phase.
- R4: An edge whose interval exceeds MAX_PERIOD becomes the new reference point but clears lock.
- R5: While locked, `phase` equals floor(256·k/P) mod 256, where k counts cycles from 0 in the first cycle after the reference edge. While unlocked, `phase` is 0.
- R6: If 2·MAX_PERIOD cycles pass after a reference edge with no further reference edge, lock is dropped and `sync_lost` rises.
- R7: While `zc_enable` is low, edges on `zc_raw` are ignored. The timers still run, so lock is eventually lost.
- R8: `tx_req_ready` is the inverse of a pending request. A request is accepted on a cycle with both `tx_req_valid` and `tx_req_ready` high.
- R9: When a request is pending and locked, `tx_start` pulses for exactly one cycle, in the cycle after the one in which `phase` equals `tx_offset`, with `tx_unsync` low.
- R10: When a request is pending and unlocked, including when lock is lost while the request is waiting, `tx_start` pulses in the next cycle with `tx_unsync` high.
- R11: A `rx_detect` pulse, taken while the slot is empty or being drained in the same cycle, loads `rx_ts_phase` with `phase` and `rx_ts_insync` with the lock state of that cycle. `rx_ts_valid` rises in the next cycle.
- R12: While `rx_ts_valid` is high and `rx_ts_ready` is low, the slot contents stay stable and new detects are dropped. If `rx_ts_ready` is high and no detect is taken, `rx_ts_valid` falls in the next cycle.
- R13: After reset, the outputs are: `sync_lost` = 1, `phase` = 0, `tx_req_ready` = 1, `tx_start` = 0, `tx_unsync` = 0 and `rx_ts_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| zc_raw | input | 1 | Asynchronous pulse from the zero-crossing detector |
| zc_enable | input | 1 | Enables zero-crossing detection on the shared pin |
| tx_offset | input | 8 | Transmit phase offset, in units of 1/256 of a period |
| tx_req_valid | input | 1 | Transmit request |
| tx_req_ready | output | 1 | High when no request is pending |
| tx_start | output | 1 | One-cycle transmit start strobe |
| tx_unsync | output | 1 | Qualifies `tx_start`: release happened without lock |
| rx_detect | input | 1 | Receive packet detected (one-cycle pulse) |
| rx_ts_valid | output | 1 | Captured phase available |
| rx_ts_ready | input | 1 | Consumer takes the captured phase |
| rx_ts_phase | output | 8 | Mains phase at the time of detection |
| rx_ts_insync | output | 1 | Lock state at the time of detection |
| phase | output | 8 | Current mains phase |
| sync_lost | output | 1 | High while not locked to the mains |

## Verification
The assertions assume that MIN_PERIOD is greater than 256, so the phase advances by at most one step per cycle. They also assume that `tx_offset` stays constant while a request is pending, because the release condition compares against the offset's value at that moment. The bench holds the offset fixed from each request until the strobe. It uses periods of several hundred cycles with a reduced window, and makes its pulses and glitches at least three cycles wide so that every edge passes the synchroniser. It also covers the corner cases: glitches inside a period, late and missing pulses, detection turned off, and receive captures that collide with back-pressure.

// File: rtl/mpt_pkg.sv
package mpt_pkg;
  localparam int PHASE_W     = 8;
  localparam int PHASE_STEPS = 1 << PHASE_W;

  typedef logic [PHASE_W-1:0] phase_t;

  typedef struct packed {
    phase_t ph;
    logic   insync;
  } stamp_t;
endpackage

// File: rtl/mpt_edge_sync.sv
module mpt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic en,
  output logic rise
);
  // sh[STAGES-1] is the last synchroniser flop, sh[STAGES] the history flop
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign rise = en & sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/mpt_period_track.sv
module mpt_period_track #(
  parameter int MIN_PERIOD = 750000,
  parameter int MAX_PERIOD = 1150000,
  parameter int CNT_W      = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_in,
  output logic             restart,
  output logic             locked,
  output logic [CNT_W-1:0] period
);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_PERIOD);
  localparam logic [CNT_W-1:0] MAX_V = CNT_W'(MAX_PERIOD);
  localparam logic [CNT_W-1:0] TMO_V = CNT_W'(2 * MAX_PERIOD);

  logic [CNT_W-1:0] t;
  logic [CNT_W-1:0] meas;
  logic             early, late;

  assign meas    = t + CNT_W'(1);
  assign early   = meas < MIN_V;
  assign late    = meas > MAX_V;
  assign restart = edge_in & ~early;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t      <= '0;
      locked <= 1'b0;
      period <= MAX_V;
    end else if (restart) begin
      t <= '0;
      if (late) begin
        locked <= 1'b0;
      end else begin
        locked <= 1'b1;
        period <= meas;
      end
    end else begin
      if (t != TMO_V) t <= t + CNT_W'(1);
      if (locked && t == TMO_V - CNT_W'(1)) locked <= 1'b0;
    end
  end

  AST_PERIOD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (period >= MIN_V && period <= MAX_V)); // R2
  AST_LOCK_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(edge_in)); // R2
  AST_TIMER_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    t <= TMO_V); // R6
endmodule

// File: rtl/mpt_phase_gen.sv
module mpt_phase_gen
  import mpt_pkg::*;
#(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             locked,
  input  logic [CNT_W-1:0] period,
  output phase_t           phase
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(PHASE_STEPS);

  logic [CNT_W-1:0] acc;
  logic [CNT_W-1:0] sum;

  assign sum = acc + STEP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc   <= '0;
      phase <= '0;
    end else if (restart || !locked) begin
      acc   <= '0;
      phase <= '0;
    end else if (sum >= period) begin
      acc   <= sum - period;
      phase <= phase + phase_t'(1);
    end else begin
      acc <= sum;
    end
  end

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !restart) |=> (phase == $past(phase) || phase == $past(phase) + 8'd1)); // R5
  AST_UNLOCKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |=> phase == 8'd0); // R5
endmodule

// File: rtl/mpt_event_unit.sv
module mpt_event_unit
  import mpt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   locked,
  input  phase_t phase,
  input  phase_t tx_offset,
  input  logic   tx_req_valid,
  output logic   tx_req_ready,
  output logic   tx_start,
  output logic   tx_unsync,
  input  logic   rx_detect,
  input  logic   rx_ts_ready,
  output logic   rx_ts_valid,
  output phase_t rx_ts_phase,
  output logic   rx_ts_insync
);
  logic   pending;
  logic   fire;
  logic   take;
  stamp_t slot;

  assign tx_req_ready = ~pending;
  assign fire         = pending & (~locked | (phase == tx_offset));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      tx_start  <= 1'b0;
      tx_unsync <= 1'b0;
    end else begin
      if (!pending)  pending <= tx_req_valid;
      else if (fire) pending <= 1'b0;
      tx_start  <= fire;
      tx_unsync <= fire & ~locked;
    end
  end

  assign take = rx_detect & (~rx_ts_valid | rx_ts_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_ts_valid <= 1'b0;
      slot        <= '0;
    end else if (take) begin
      rx_ts_valid <= 1'b1;
      slot        <= '{ph: phase, insync: locked};
    end else if (rx_ts_ready) begin
      rx_ts_valid <= 1'b0;
    end
  end

  assign rx_ts_phase  = slot.ph;
  assign rx_ts_insync = slot.insync;

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start); // R9
  AST_START_AT_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && !tx_unsync) |-> ($past(phase) == $past(tx_offset) && $past(locked))); // R9
  AST_UNSYNC_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && tx_unsync) |-> !$past(locked)); // R10
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ts_valid && !rx_ts_ready) |=> (rx_ts_valid && $stable(rx_ts_phase) && $stable(rx_ts_insync))); // R12
endmodule

// File: rtl/mains_phase_timer.sv
module mains_phase_timer
  import mpt_pkg::*;
#(
  parameter int MIN_PERIOD  = 750000,
  parameter int MAX_PERIOD  = 1150000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       zc_raw,
  input  logic       zc_enable,
  input  logic [7:0] tx_offset,
  input  logic       tx_req_valid,
  output logic       tx_req_ready,
  output logic       tx_start,
  output logic       tx_unsync,
  input  logic       rx_detect,
  output logic       rx_ts_valid,
  input  logic       rx_ts_ready,
  output logic [7:0] rx_ts_phase,
  output logic       rx_ts_insync,
  output logic [7:0] phase,
  output logic       sync_lost
);
  localparam int CNT_W = $clog2(2 * MAX_PERIOD + 2);

  logic             zc_rise;
  logic             restart;
  logic             locked;
  logic [CNT_W-1:0] period;

  mpt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(zc_raw), .en(zc_enable), .rise(zc_rise)
  );

  mpt_period_track #(
    .MIN_PERIOD(MIN_PERIOD), .MAX_PERIOD(MAX_PERIOD), .CNT_W(CNT_W)
  ) u_track (
    .clk(clk), .rst_n(rst_n), .edge_in(zc_rise),
    .restart(restart), .locked(locked), .period(period)
  );

  mpt_phase_gen #(.CNT_W(CNT_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .restart(restart), .locked(locked),
    .period(period), .phase(phase)
  );

  mpt_event_unit u_evt (
    .clk(clk), .rst_n(rst_n), .locked(locked), .phase(phase),
    .tx_offset(tx_offset), .tx_req_valid(tx_req_valid),
    .tx_req_ready(tx_req_ready), .tx_start(tx_start), .tx_unsync(tx_unsync),
    .rx_detect(rx_detect), .rx_ts_ready(rx_ts_ready), .rx_ts_valid(rx_ts_valid),
    .rx_ts_phase(rx_ts_phase), .rx_ts_insync(rx_ts_insync)
  );

  assign sync_lost = ~locked;
endmodule

// File: tb/test_mains_phase_timer.sv
module test_mains_phase_timer;
  localparam int MINP = 300;
  localparam int MAXP = 700;
  localparam int TO   = 2 * MAXP;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       zc_raw = 1'b0;
  logic       zc_enable = 1'b1;
  logic [7:0] tx_offset = 8'd0;
  logic       tx_req_valid = 1'b0;
  logic       rx_detect = 1'b0;
  logic       rx_ts_ready = 1'b0;
  logic       tx_req_ready, tx_start, tx_unsync, rx_ts_valid, rx_ts_insync, sync_lost;
  logic [7:0] rx_ts_phase, phase;

  always #10 clk = ~clk;

  mains_phase_timer #(.MIN_PERIOD(MINP), .MAX_PERIOD(MAXP)) i_mains_phase_timer (
    .clk(clk), .rst_n(rst_n), .zc_raw(zc_raw), .zc_enable(zc_enable),
    .tx_offset(tx_offset), .tx_req_valid(tx_req_valid), .tx_req_ready(tx_req_ready),
    .tx_start(tx_start), .tx_unsync(tx_unsync), .rx_detect(rx_detect),
    .rx_ts_valid(rx_ts_valid), .rx_ts_ready(rx_ts_ready), .rx_ts_phase(rx_ts_phase),
    .rx_ts_insync(rx_ts_insync), .phase(phase), .sync_lost(sync_lost)
  );

  int    vecs = 0;
  int    miss = 0;
  bit    cmp_on = 0;
  string cur_tag = "R13 reset";

  // behavioural reference state
  int z1, z2, z3, mt, mlock, mper, mk, mphase;
  int mpend, mstart, munsync, mrv, mrph, mrsync;
  int e, meas, rs, lt, fire, take;

  task automatic cmp(string tag, string name, int act, int exp);
    vecs++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s [%s] %s: got %0d expected %0d", tag, cur_tag, name, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      z1 = 0; z2 = 0; z3 = 0; mt = 0; mlock = 0; mper = MAXP; mk = 0; mphase = 0;
      mpend = 0; mstart = 0; munsync = 0; mrv = 0; mrph = 0; mrsync = 0;
    end else begin
      e    = (zc_enable && z2 && !z3) ? 1 : 0;
      meas = mt + 1;
      rs   = (e && meas >= MINP) ? 1 : 0;
      lt   = (meas > MAXP) ? 1 : 0;
      fire = (mpend && (!mlock || mphase == int'(tx_offset))) ? 1 : 0;
      take = (rx_detect && (!mrv || rx_ts_ready)) ? 1 : 0;
      mstart  = fire;
      munsync = (fire && !mlock) ? 1 : 0;
      if (!mpend) mpend = tx_req_valid ? 1 : 0;
      else if (fire) mpend = 0;
      if (take) begin
        mrv = 1; mrph = mphase; mrsync = mlock;
      end else if (rx_ts_ready) mrv = 0;
      if (rs || !mlock) begin
        mk = 0; mphase = 0;
      end else begin
        mk = mk + 1;
        mphase = int'(((longint'(mk) * 256) / mper) % 256);
      end
      if (rs) begin
        mt = 0;
        if (lt) mlock = 0;
        else begin mlock = 1; mper = meas; end
      end else begin
        if (mlock && mt == TO - 1) mlock = 0;
        if (mt < TO) mt = mt + 1;
      end
      z3 = z2; z2 = z1; z1 = zc_raw ? 1 : 0;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      cmp("R5",  "phase",        phase,        mphase);
      cmp("R6",  "sync_lost",    sync_lost,    mlock ? 0 : 1);
      cmp("R8",  "tx_req_ready", tx_req_ready, mpend ? 0 : 1);
      cmp("R9",  "tx_start",     tx_start,     mstart);
      cmp("R10", "tx_unsync",    tx_unsync,    munsync);
      cmp("R11", "rx_ts_valid",  rx_ts_valid,  mrv);
      if (mrv) begin
        cmp("R11", "rx_ts_phase",  rx_ts_phase,  mrph);
        cmp("R11", "rx_ts_insync", rx_ts_insync, mrsync);
      end
    end
  end

  task automatic train(int n, int per, int glitch);
    for (int i = 0; i < n; i++) begin
      zc_raw = 1'b1;
      repeat (20) @(negedge clk);
      zc_raw = 1'b0;
      if (glitch > 0) begin
        repeat (glitch - 20) @(negedge clk);
        zc_raw = 1'b1;
        repeat (3) @(negedge clk);
        zc_raw = 1'b0;
        repeat (per - glitch - 3) @(negedge clk);
      end else begin
        repeat (per - 20) @(negedge clk);
      end
    end
  endtask

  task automatic send_tx(int off);
    tx_offset = off[7:0];
    while (!tx_req_ready) @(negedge clk);
    tx_req_valid = 1'b1;
    @(negedge clk);
    tx_req_valid = 1'b0;
    @(negedge clk);
    while (!tx_req_ready) @(negedge clk);
  endtask

  task automatic det_pulse();
    rx_detect = 1'b1;
    @(negedge clk);
    rx_detect = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miss++;
    $display("FAIL watchdog: got hung run expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1;
    // R13: state right after reset
    cmp("R13", "sync_lost",    sync_lost,    1);
    cmp("R13", "phase",        phase,        0);
    cmp("R13", "tx_req_ready", tx_req_ready, 1);
    cmp("R13", "rx_ts_valid",  rx_ts_valid,  0);
    cmp("R13", "tx_start",     tx_start,     0);
    repeat (50) @(negedge clk);
    fork
      begin
        cur_tag = "R1 R2 lock on 500-cycle mains";
        train(8, 500, 0);
        cur_tag = "R3 glitch inside period";
        train(2, 500, 120);
        cur_tag = "R2 new period 650";
        train(4, 650, 0);
      end
      begin
        repeat (1200) @(negedge clk);
        send_tx(77);   // R9
        send_tx(0);    // R9
        send_tx(200);  // R9
        send_tx(255);  // R9
        // R12: back-pressure, second detect dropped
        rx_ts_ready = 1'b0;
        det_pulse();
        repeat (40) @(negedge clk);
        det_pulse();
        repeat (30) @(negedge clk);
        // capture while draining in the same cycle
        rx_ts_ready = 1'b1;
        det_pulse();
        repeat (3) @(negedge clk);
        rx_ts_ready = 1'b0;
      end
    join
    // R2: lock must hold on the 650 train
    cmp("R2", "sync_lost", sync_lost, 0);
    cur_tag = "R4 late edge";
    zc_raw = 1'b0;
    repeat (300) @(negedge clk);
    train(3, 650, 0);
    cur_tag = "R6 no pulses";
    repeat (TO + 300) @(negedge clk);
    cmp("R6", "sync_lost", sync_lost, 1);
    cur_tag = "R10 unsynchronised request";
    send_tx(30);
    rx_ts_ready = 1'b1;
    det_pulse();   // R11 capture while unlocked
    repeat (5) @(negedge clk);
    cur_tag = "R7 detection disabled";
    zc_enable = 1'b0;
    train(4, 500, 0);
    cmp("R7", "sync_lost", sync_lost, 1);
    zc_enable = 1'b1;
    cur_tag = "R2 relock";
    train(4, 500, 0);
    send_tx(128);
    repeat (20) @(negedge clk);
    summary();
    $finish;
  end
endmodule